// File: doc/BRIEF.md
# JTAG Pin Enable Multiplexer

This block decides whether four shared port pins act as a JTAG test port or as general-purpose I/O. A single JTAG-on signal is formed from three independent sources: a static configuration enable, a run-time enable bit that a microcontroller writes over a byte-wide register bus, and an external logic-term enable. When JTAG-on is low, the pins are driven from the GPIO data and direction signals. When it is high, they are routed to the JTAG core interface.

With JTAG-on high, all four pins start as inputs, TDO included. TDO becomes a driven output only after the TAP reports an enabling command. The same command can also turn on two dedicated status outputs, test-status and test-error, when a separate configuration option is set. The TAP state machine and boundary-scan logic sit outside this block. A one-cycle command strobe from the TAP stands in for them.

Top module: `jtag_pin_mux`

## Requirements
- R1: `jtag_on_o` is high in the same cycle whenever any of `cfg_jtag_en_i`, `lt_jtag_en_i` or the register enable bit is 1, and low otherwise.
- R2: A bus write (`bus_wr_i`=1) to offset 0xC7 loads `bus_wdata_i[0]` into the register enable bit at the clock edge. A 1 enables the port and a 0 disables it.
- R3: While `bus_rd_i`=1 and `bus_addr_i`=0xC7, `bus_rdata_o` equals {7'b0, enable bit}, so bits 7..1 read 0 even after being written as 1. Reads of any other offset, and cycles with no read, return 0.
- R4: A write to any offset other than 0xC7 leaves the enable bit unchanged.
- R5: Reset (`rst_ni`=0, asynchronous) clears the enable bit and the TDO drive latch.
- R6: With JTAG-on low, `pad_out_o`=`gpio_out_i`, `pad_oe_o`=`gpio_oe_i` and `gpio_in_o`=`pad_in_i` on all four pins. The JTAG core sees TMS=1, TCK=0 and TDI=0.
- R7: With JTAG-on high, the pin order is TMS=0, TCK=1, TDI=2 and TDO=3. `pad_oe_o[2:0]`=0 and `pad_out_o[2:0]`=0. `jtag_tms_o`, `jtag_tck_o` and `jtag_tdi_o` follow `pad_in_i[0]`, `pad_in_i[1]` and `pad_in_i[2]`. `gpio_in_o`=0.
- R8: In the first cycle of JTAG-on, `pad_oe_o[3]`=0. A `tap_cmd_en_i` pulse sampled while JTAG-on is high sets `pad_oe_o[3]` from the next cycle on. `pad_out_o[3]` carries `tap_tdo_i` in JTAG mode.
- R9: When JTAG-on drops, pin 3 returns to GPIO control in the same cycle and the TDO latch clears. A command sampled while JTAG-on is low has no effect, so re-enabling needs a new command.
- R10: `stat_oe_o` and `err_oe_o` are high only while the TDO latch is set, JTAG-on is high and `cfg_stat_en_i`=1. `stat_o` and `err_o` carry `tap_stat_i` and `tap_err_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_jtag_en_i | input | 1 | Static configuration enable |
| cfg_stat_en_i | input | 1 | Option enabling the status/error pins |
| lt_jtag_en_i | input | 1 | External logic-term enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| tap_cmd_en_i | input | 1 | Enabling-command strobe from the TAP |
| tap_tdo_i | input | 1 | TDO data from the TAP |
| tap_stat_i | input | 1 | Test-status value from the TAP |
| tap_err_i | input | 1 | Test-error value from the TAP |
| jtag_on_o | output | 1 | Combined JTAG-on |
| jtag_tms_o | output | 1 | TMS to the TAP |
| jtag_tck_o | output | 1 | TCK to the TAP |
| jtag_tdi_o | output | 1 | TDI to the TAP |
| gpio_out_i | input | 4 | GPIO output data |
| gpio_oe_i | input | 4 | GPIO output enables |
| gpio_in_o | output | 4 | GPIO input data |
| pad_in_i | input | 4 | Pin input values |
| pad_out_o | output | 4 | Pin output values |
| pad_oe_o | output | 4 | Pin output enables |
| stat_o | output | 1 | Test-status pin value |
| stat_oe_o | output | 1 | Test-status pin enable |
| err_o | output | 1 | Test-error pin value |
| err_oe_o | output | 1 | Test-error pin enable |

## Verification
The pin routing, JTAG-on and read data are combinational. The bench checks them in the same cycle the stimulus is applied, a short settle delay after driving on the falling edge. Register writes, TDO commands and their effects pass through one flop. The bench drives them on a falling edge and samples at the next falling edge, after the single rising edge that captures them. Reset acts asynchronously, so its checks are sampled during reset, before any edge.

// File: rtl/jtag_pin_mux_pkg.sv
package jtag_pin_mux_pkg;
  localparam int unsigned NUM_PINS = 4;
  localparam int unsigned PIN_TMS  = 0;
  localparam int unsigned PIN_TCK  = 1;
  localparam int unsigned PIN_TDI  = 2;
  localparam int unsigned PIN_TDO  = 3;

  // Idle levels presented to the TAP while pins belong to GPIO
  localparam logic IDLE_TMS = 1'b1;
  localparam logic IDLE_TCK = 1'b0;
  localparam logic IDLE_TDI = 1'b0;
endpackage

// File: rtl/jtag_en_reg.sv
module jtag_en_reg #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFFSET = 'hC7,
  parameter int unsigned EN_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

  logic hit;
  logic en_q;

  assign hit = (addr_i == HIT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          en_q <= 1'b0;
    else if (wr_i && hit) en_q <= wdata_i[EN_BIT];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i && hit) rdata_o[EN_BIT] = en_q;
  end

  assign en_o = en_q;
endmodule

// File: rtl/jtag_tdo_ctl.sv
module jtag_tdo_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic jtag_on_i,
  input  logic cmd_i,
  input  logic stat_en_i,
  output logic tdo_oe_o,
  output logic stat_oe_o
);
  logic drv_q;

  // Set by a command while on; dropped as soon as on falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b0;
    else         drv_q <= jtag_on_i & (drv_q | cmd_i);
  end

  assign tdo_oe_o  = jtag_on_i & drv_q;
  assign stat_oe_o = jtag_on_i & drv_q & stat_en_i;
endmodule

// File: rtl/jtag_pad_route.sv
module jtag_pad_route
  import jtag_pin_mux_pkg::*;
(
  input  logic                jtag_on_i,
  input  logic                tdo_oe_i,
  input  logic                tap_tdo_i,
  input  logic [NUM_PINS-1:0] gpio_out_i,
  input  logic [NUM_PINS-1:0] gpio_oe_i,
  output logic [NUM_PINS-1:0] gpio_in_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                tms_o,
  output logic                tck_o,
  output logic                tdi_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p == PIN_TDO) begin : g_tdo
      assign pad_out_o[p] = jtag_on_i ? tap_tdo_i : gpio_out_i[p];
      assign pad_oe_o[p]  = jtag_on_i ? tdo_oe_i  : gpio_oe_i[p];
    end else begin : g_in
      assign pad_out_o[p] = jtag_on_i ? 1'b0 : gpio_out_i[p];
      assign pad_oe_o[p]  = jtag_on_i ? 1'b0 : gpio_oe_i[p];
    end
    assign gpio_in_o[p] = jtag_on_i ? 1'b0 : pad_in_i[p];
  end

  assign tms_o = jtag_on_i ? pad_in_i[PIN_TMS] : IDLE_TMS;
  assign tck_o = jtag_on_i ? pad_in_i[PIN_TCK] : IDLE_TCK;
  assign tdi_o = jtag_on_i ? pad_in_i[PIN_TDI] : IDLE_TDI;
endmodule

// File: rtl/jtag_pin_mux.sv
module jtag_pin_mux
  import jtag_pin_mux_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned EN_OFFSET = 'hC7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_jtag_en_i,
  input  logic                cfg_stat_en_i,
  input  logic                lt_jtag_en_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic                tap_cmd_en_i,
  input  logic                tap_tdo_i,
  input  logic                tap_stat_i,
  input  logic                tap_err_i,
  output logic                jtag_on_o,
  output logic                jtag_tms_o,
  output logic                jtag_tck_o,
  output logic                jtag_tdi_o,
  input  logic [NUM_PINS-1:0] gpio_out_i,
  input  logic [NUM_PINS-1:0] gpio_oe_i,
  output logic [NUM_PINS-1:0] gpio_in_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                stat_o,
  output logic                stat_oe_o,
  output logic                err_o,
  output logic                err_oe_o
);
  logic sw_en;
  logic jtag_on;
  logic tdo_oe;
  logic aux_oe;

  jtag_en_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFFSET (EN_OFFSET),
    .EN_BIT (0)
  ) i_en_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .en_o    (sw_en)
  );

  assign jtag_on = cfg_jtag_en_i | sw_en | lt_jtag_en_i;

  jtag_tdo_ctl i_tdo_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .jtag_on_i (jtag_on),
    .cmd_i     (tap_cmd_en_i),
    .stat_en_i (cfg_stat_en_i),
    .tdo_oe_o  (tdo_oe),
    .stat_oe_o (aux_oe)
  );

  jtag_pad_route i_route (
    .jtag_on_i  (jtag_on),
    .tdo_oe_i   (tdo_oe),
    .tap_tdo_i  (tap_tdo_i),
    .gpio_out_i (gpio_out_i),
    .gpio_oe_i  (gpio_oe_i),
    .gpio_in_o  (gpio_in_o),
    .pad_in_i   (pad_in_i),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o),
    .tms_o      (jtag_tms_o),
    .tck_o      (jtag_tck_o),
    .tdi_o      (jtag_tdi_o)
  );

  assign jtag_on_o = jtag_on;
  assign stat_o    = tap_stat_i;
  assign err_o     = tap_err_i;
  assign stat_oe_o = aux_oe;
  assign err_oe_o  = aux_oe;
endmodule

// File: rtl/jtag_pin_mux_chk.sv
module jtag_pin_mux_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned EN_OFFSET = 'hC7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_jtag_en_i,
  input logic              cfg_stat_en_i,
  input logic              lt_jtag_en_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              tap_cmd_en_i,
  input logic              jtag_on_o,
  input logic [3:0]        pad_oe_o,
  input logic              stat_oe_o
);
  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(EN_OFFSET);

  a_r1_source_forces_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_jtag_en_i || lt_jtag_en_i) |-> jtag_on_o);

  a_r2_write_sets_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == HIT && bus_wdata_i[0]) |=> jtag_on_o);

  a_r7_inputs_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jtag_on_o |-> (pad_oe_o[2:0] == 3'b000));

  a_r8_tdo_starts_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jtag_on_o ##1 jtag_on_o |-> !pad_oe_o[3]);

  a_r9_tdo_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jtag_on_o && !pad_oe_o[3] && !tap_cmd_en_i) |=> (!jtag_on_o || !pad_oe_o[3]));

  a_r10_stat_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_oe_o |-> (cfg_stat_en_i && jtag_on_o && pad_oe_o[3]));
endmodule

bind jtag_pin_mux jtag_pin_mux_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .EN_OFFSET (EN_OFFSET)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_jtag_en_i (cfg_jtag_en_i),
  .cfg_stat_en_i (cfg_stat_en_i),
  .lt_jtag_en_i  (lt_jtag_en_i),
  .bus_wr_i      (bus_wr_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .tap_cmd_en_i  (tap_cmd_en_i),
  .jtag_on_o     (jtag_on_o),
  .pad_oe_o      (pad_oe_o),
  .stat_oe_o     (stat_oe_o)
);

// File: tb/test_jtag_pin_mux.sv
`timescale 1ns/1ps
module test_jtag_pin_mux;
  localparam time TCLK = 8ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 0, cfg_stat = 0, lt_en = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic       cmd = 0, tdo = 0, tstat = 0, terr = 0;
  logic       on, tms, tck, tdi;
  logic [3:0] g_out = 0, g_oe = 0, g_in, p_in = 0, p_out, p_oe;
  logic       st, st_oe, er, er_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  jtag_pin_mux i_jtag_pin_mux (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_jtag_en_i(cfg_en), .cfg_stat_en_i(cfg_stat), .lt_jtag_en_i(lt_en),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .tap_cmd_en_i(cmd), .tap_tdo_i(tdo), .tap_stat_i(tstat), .tap_err_i(terr),
    .jtag_on_o(on), .jtag_tms_o(tms), .jtag_tck_o(tck), .jtag_tdi_o(tdi),
    .gpio_out_i(g_out), .gpio_oe_i(g_oe), .gpio_in_o(g_in),
    .pad_in_i(p_in), .pad_out_o(p_out), .pad_oe_o(p_oe),
    .stat_o(st), .stat_oe_o(st_oe), .err_o(er), .err_oe_o(er_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
    #1;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    rd = 1; addr = a;
    #1;
    d = rdata;
    rd = 0;
  endtask

  task automatic pulse_cmd();
    @(negedge clk);
    cmd = 1;
    @(negedge clk);
    cmd = 0;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    #1;
    chk("R5 on in reset", 32'(on), 0);
    bus_read(8'hC7, d);
    chk("R5 enable bit in reset", 32'(d), 0);
    g_oe = 4'h8;
    #1;
    chk("R5 tdo pin follows gpio in reset", 32'(p_oe), 32'h8);
    g_oe = 0;
    settle(); settle();
    rst_n = 1;
    settle();
  endtask

  task automatic t_gpio();
    g_out = 4'hA; g_oe = 4'h5; p_in = 4'h3;
    #1;
    chk("R6 pad_out", 32'(p_out), 32'hA);
    chk("R6 pad_oe", 32'(p_oe), 32'h5);
    chk("R6 gpio_in", 32'(g_in), 32'h3);
    chk("R6 tap idle", {29'd0, tms, tck, tdi}, 32'b100);
    g_out = 4'h5; g_oe = 4'hF; p_in = 4'hC;
    #1;
    chk("R6 pad_out b", 32'(p_out), 32'h5);
    chk("R6 pad_oe b", 32'(p_oe), 32'hF);
    chk("R6 gpio_in b", 32'(g_in), 32'hC);
  endtask

  task automatic t_sources();
    cfg_en = 1; #1;
    chk("R1 cfg source", 32'(on), 1);
    cfg_en = 0; lt_en = 1; #1;
    chk("R1 logic-term source", 32'(on), 1);
    lt_en = 0; #1;
    chk("R1 no source", 32'(on), 0);
  endtask

  task automatic t_reg();
    logic [7:0] d;
    bus_write(8'hC7, 8'hFF);
    chk("R2 write 1 enables", 32'(on), 1);
    bus_read(8'hC7, d);
    chk("R3 read upper bits zero", 32'(d), 32'h01);
    bus_write(8'hC6, 8'h00);
    chk("R4 other offset keeps bit", 32'(on), 1);
    bus_write(8'h47, 8'h00);
    chk("R4 aliasing offset keeps bit", 32'(on), 1);
    bus_read(8'hC6, d);
    chk("R3 other offset reads zero", 32'(d), 0);
    addr = 8'hC7; #1;
    chk("R3 no strobe reads zero", 32'(rdata), 0);
    bus_write(8'hC7, 8'hFE);
    chk("R2 write 0 disables", 32'(on), 0);
    bus_read(8'hC7, d);
    chk("R3 read after clear", 32'(d), 0);
  endtask

  task automatic t_route();
    g_out = 4'hF; g_oe = 4'hF; p_in = 4'b0101;
    lt_en = 1; #1;
    chk("R7 pins 0..2 undriven", 32'(p_oe[2:0]), 0);
    chk("R7 pins 0..2 out zero", 32'(p_out[2:0]), 0);
    chk("R7 tms/tck/tdi", {29'd0, tms, tck, tdi}, 32'b101);
    chk("R7 gpio_in zero", 32'(g_in), 0);
    chk("R8 tdo off on entry", 32'(p_oe[3]), 0);
    p_in = 4'b1010; #1;
    chk("R7 tms/tck/tdi b", {29'd0, tms, tck, tdi}, 32'b010);
    settle();
    chk("R8 tdo still off without cmd", 32'(p_oe[3]), 0);
  endtask

  task automatic t_tdo();
    cfg_stat = 0;
    pulse_cmd();
    chk("R8 tdo driven after cmd", 32'(p_oe[3]), 1);
    tdo = 1; #1;
    chk("R8 tdo data 1", 32'(p_out[3]), 1);
    tdo = 0; #1;
    chk("R8 tdo data 0", 32'(p_out[3]), 0);
    chk("R10 stat off without option", {30'd0, st_oe, er_oe}, 0);
    cfg_stat = 1; tstat = 1; terr = 0; #1;
    chk("R10 stat/err enabled", {30'd0, st_oe, er_oe}, 32'b11);
    chk("R10 stat/err values", {30'd0, st, er}, 32'b10);
    settle();
    chk("R8 tdo stays driven", 32'(p_oe[3]), 1);
  endtask

  task automatic t_drop();
    g_oe = 4'h0;
    lt_en = 0; #1;
    chk("R9 pin 3 back to gpio", 32'(p_oe[3]), 0);
    chk("R10 stat off when jtag off", {30'd0, st_oe, er_oe}, 0);
    settle();
    lt_en = 1; #1;
    chk("R9 latch cleared on drop", 32'(p_oe[3]), 0);
    lt_en = 0;
    pulse_cmd();
    lt_en = 1; #1;
    chk("R9 cmd ignored while off", 32'(p_oe[3]), 0);
    settle();
    chk("R9 still off next cycle", 32'(p_oe[3]), 0);
    lt_en = 0; cfg_stat = 0;
  endtask

  task automatic t_reset2();
    logic [7:0] d;
    bus_write(8'hC7, 8'h01);
    pulse_cmd();
    chk("R8 tdo driven via register", 32'(p_oe[3]), 1);
    rst_n = 0; #1;
    chk("R5 reset clears enable", 32'(on), 0);
    settle();
    rst_n = 1;
    settle();
    bus_read(8'hC7, d);
    chk("R5 bit cleared after reset", 32'(d), 0);
    cfg_en = 1; #1;
    chk("R5 latch cleared by reset", 32'(p_oe[3]), 0);
    cfg_en = 0;
  endtask

  initial begin
    t_reset();
    t_gpio();
    t_sources();
    t_reg();
    t_route();
    t_tdo();
    t_drop();
    t_reset2();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule